// File: doc/BRIEF.md
# Folded symmetric FIR filter

This block is a time-multiplexed FIR filter for linear-phase coefficient sets, where coefficient k equals coefficient TAPS-1-k. It stores only the first half of the set. For each output it adds each pair of mirrored history samples before the multiply, so one multiplier-accumulator covers two taps per cycle. When TAPS is odd, the centre sample is multiplied alone. The sum is kept at full precision, with a growth of ceil(log2(TAPS)) bits over the product width, and is never rounded or clipped.

A sample is taken on `in_data` in a cycle where both `in_valid` and `in_ready` are high. The block then lowers `in_ready` and runs through the ceil(TAPS/2) coefficient products. It then shows the result with a one-cycle `out_valid` pulse, and `in_ready` returns high in that same cycle. An optional tag entered with the sample on `in_id` comes back on `out_id` with its result. The coefficient half-set is driven on `coef_i` by a separate coefficient controller. That controller must hold the half-set stable while an accumulation runs.

Top module: `sym_fir_folded`

## Requirements
- R1: `out_data` is the exact signed sum over k = 0..TAPS-1 of h[k]·x[n-k]. Data, coefficients and result are two's complement. x[n] is the newest accepted sample. The result is OUT_W = DATA_W + COEF_W + ceil(log2(TAPS)) bits wide, with no rounding or saturation, so that extreme inputs and coefficients give the exact value.
- R2: `coef_i` carries h[0..H-1], where H = ceil(TAPS/2), with h[k] in bits [k·COEF_W +: COEF_W]. The coefficient h[k] is applied to history positions k and TAPS-1-k. When TAPS is odd, the centre position (TAPS-1)/2 gets its coefficient once.
- R3: `in_ready` is high when the block is idle. After an accepted sample it is low for exactly H cycles, and it rises again in the cycle where `out_valid` is high.
- R4: Values presented on `in_data`/`in_id` with `in_valid` high while `in_ready` is low are not accepted. They do not enter the history, and they do not change the pending result or tag.
- R5: `out_valid` is a single-cycle pulse in the cycle H+1 clock edges after the accepting edge. `out_data` and `out_id` stay unchanged whenever `out_valid` is low.
- R6: When USE_ID is 1, `out_id` during the `out_valid` pulse equals the `in_id` value taken with the sample that produced the result.
- R7: While `rst_n` is low, and without waiting for a clock edge, `out_valid` is 0, `out_data` and `out_id` are 0, `in_ready` is 1, and the history becomes all zeros. Any running accumulation is abandoned.
- R8: A clock edge with `srst_n` low has the same effect as R7 on all registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W | Input sample, signed |
| in_valid | input | 1 | Input sample present |
| in_id | input | ID_W | Tag travelling with the input sample |
| coef_i | input | H·COEF_W | First half of the symmetric coefficient set, signed |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_data | output | OUT_W | Full-precision filtered result, signed |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_id | output | ID_W | Tag of the sample behind the current result |

## Verification
A result is due in the cycle after the (H+1)-th rising edge that follows the accepting edge. For the default 7 taps that is the fifth edge. `in_ready` must read low from the first cycle after acceptance until that point. The bench counts falling edges from the accept and samples `in_ready`, `out_valid`, `out_data` and `out_id` at exactly the due falling edge. It samples them again one edge later to confirm that the result is held and the pulse has ended. The expected sum comes from a direct-form convolution over a history the bench keeps itself. During the busy cycles the bench can drive garbage with `in_valid` high, and the reference then shows whether that garbage leaked in. The asynchronous reset is checked one time step after it is asserted. The synchronous reset is checked after the edge that sees it.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sfir_state_e;
endpackage

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps_flat
);
  // Position 0 holds the newest accepted sample.
  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    logic [DATA_W-1:0] stage_d;
    logic [DATA_W-1:0] stage_q;

    if (g == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_link
      assign stage_d = taps_flat[(g-1)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else if (!srst_n) begin
        stage_q <= '0;
      end else if (shift_en) begin
        stage_q <= stage_d;
      end
    end

    assign taps_flat[g*DATA_W +: DATA_W] = stage_q;
  end
endmodule

// File: rtl/sfir_preadd.sv
module sfir_preadd #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 7,
  parameter int HALF   = (TAPS + 1) / 2,
  parameter int IDX_W  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic [TAPS*DATA_W-1:0]   taps_flat,
  input  logic [IDX_W-1:0]         idx,
  output logic signed [DATA_W:0]   pre
);
  logic signed [DATA_W:0] near_s;
  logic signed [DATA_W:0] far_s;

  always_comb begin
    near_s = '0;
    far_s  = '0;
    for (int k = 0; k < HALF; k++) begin
      if (int'(idx) == k) begin
        near_s = (DATA_W+1)'($signed(taps_flat[k*DATA_W +: DATA_W]));
        if (2 * k != TAPS - 1) begin
          far_s = (DATA_W+1)'($signed(taps_flat[(TAPS-1-k)*DATA_W +: DATA_W]));
        end
      end
    end
    pre = near_s + far_s;
  end
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int HALF   = 4,
  parameter int OUT_W  = 19,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     last,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [DATA_W:0]   pre,
  input  logic [HALF*COEF_W-1:0]   coef_flat,
  output logic [OUT_W-1:0]         out_data
);
  localparam int PROD_W = DATA_W + 1 + COEF_W;

  logic signed [COEF_W-1:0] coef_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [OUT_W-1:0]  prod_ext;
  logic signed [OUT_W-1:0]  acc_d, acc_q;
  logic signed [OUT_W-1:0]  sum;
  logic [OUT_W-1:0]         res_d, res_q;

  always_comb begin
    coef_sel = $signed(coef_flat[idx*COEF_W +: COEF_W]);
    prod     = pre * coef_sel;
    prod_ext = OUT_W'(prod);
    sum      = acc_q + prod_ext;
    acc_d    = acc_q;
    res_d    = res_q;
    if (clr) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = sum;
    end
    if (last) begin
      res_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (!srst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign out_data = res_q;
endmodule

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
#(
  parameter int HALF   = 4,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 4,
  parameter bit USE_ID = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_n,
  input  logic             in_valid,
  input  logic [ID_W-1:0]  in_id,
  output logic             in_ready,
  output logic             accept,
  output logic             step,
  output logic             last,
  output logic [IDX_W-1:0] idx,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id
);
  sfir_state_e      state_d, state_q;
  logic [IDX_W-1:0] cnt_d, cnt_q;
  logic             valid_q;

  always_comb begin
    accept  = (state_q == ST_IDLE) && in_valid;
    step    = (state_q == ST_RUN);
    last    = step && (cnt_q == IDX_W'(HALF - 1));
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (last) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (step) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!srst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= last;
    end
  end

  if (USE_ID) begin : g_id
    logic [ID_W-1:0] id_d, id_q, oid_d, oid_q;

    always_comb begin
      id_d  = accept ? in_id : id_q;
      oid_d = last ? id_q : oid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q  <= '0;
        oid_q <= '0;
      end else if (!srst_n) begin
        id_q  <= '0;
        oid_q <= '0;
      end else begin
        id_q  <= id_d;
        oid_q <= oid_d;
      end
    end

    assign out_id = oid_q;
  end else begin : g_no_id
    assign out_id = '0;
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign idx       = cnt_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/sym_fir_folded.sv
module sym_fir_folded #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 7,
  parameter int ID_W   = 4,
  parameter bit USE_ID = 1'b1,
  localparam int HALF  = (TAPS + 1) / 2,
  localparam int OUT_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   srst_n,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_valid,
  input  logic [ID_W-1:0]        in_id,
  input  logic [HALF*COEF_W-1:0] coef_i,
  output logic                   in_ready,
  output logic [OUT_W-1:0]       out_data,
  output logic                   out_valid,
  output logic [ID_W-1:0]        out_id
);
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic                    accept;
  logic                    step;
  logic                    last;
  logic [IDX_W-1:0]        idx;
  logic [TAPS*DATA_W-1:0]  taps_flat;
  logic signed [DATA_W:0]  pre;

  sfir_ctrl #(
    .HALF(HALF), .IDX_W(IDX_W), .ID_W(ID_W), .USE_ID(USE_ID)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .in_valid(in_valid), .in_id(in_id), .in_ready(in_ready),
    .accept(accept), .step(step), .last(last), .idx(idx),
    .out_valid(out_valid), .out_id(out_id)
  );

  sfir_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .shift_en(accept), .din(in_data), .taps_flat(taps_flat)
  );

  sfir_preadd #(
    .DATA_W(DATA_W), .TAPS(TAPS), .HALF(HALF), .IDX_W(IDX_W)
  ) u_pre (
    .taps_flat(taps_flat), .idx(idx), .pre(pre)
  );

  sfir_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .HALF(HALF), .OUT_W(OUT_W), .IDX_W(IDX_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .clr(accept), .step(step), .last(last), .idx(idx),
    .pre(pre), .coef_flat(coef_i), .out_data(out_data)
  );
endmodule

// File: rtl/sfir_checker.sv
module sfir_checker #(
  parameter int HALF  = 4,
  parameter int OUT_W = 19,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic [ID_W-1:0]  out_id
);
  localparam int CW = $clog2(HALF + 3) + 1;

  logic [CW-1:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_acc <= '0;
    end else if (!srst_n) begin
      since_acc <= '0;
    end else if (in_valid && in_ready) begin
      since_acc <= CW'(1);
    end else if (out_valid) begin
      since_acc <= '0;
    end else if (since_acc != '0) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  // R3: acceptance drops ready on the next cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && srst_n) |=> !in_ready);

  // R3: ready only comes back together with a result
  p_ready_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ready) && $past(srst_n)) |-> out_valid);

  // R5: result pulse lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: result due H+1 edges after acceptance
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_acc == CW'(HALF + 1)));

  // R5: outputs held between pulses
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(srst_n)) |-> ($stable(out_data) && $stable(out_id)));

  // R8: synchronous reset clears the outputs
  p_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> (!out_valid && in_ready && out_data == '0 && out_id == '0));
endmodule

bind sym_fir_folded sfir_checker #(.HALF(HALF), .OUT_W(OUT_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_id(out_id)
);

// File: tb/sym_fir_folded_test.sv
module sym_fir_folded_test;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int N  = 7;
  localparam int IW = 4;
  localparam int H  = (N + 1) / 2;
  localparam int OW = DW + CW + $clog2(N);

  logic clk = 1'b0;
  logic rst_n, srst_n, in_valid, in_ready, out_valid;
  logic [DW-1:0]   in_data;
  logic [IW-1:0]   in_id, out_id;
  logic [H*CW-1:0] coef_i;
  logic [OW-1:0]   out_data;

  int n_chk = 0, n_bad = 0;
  longint hist [N];
  longint cf [H];
  int lcg = 12345;
  logic [IW-1:0] tag = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sym_fir_folded #(.DATA_W(DW), .COEF_W(CW), .TAPS(N), .ID_W(IW), .USE_ID(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .in_data(in_data), .in_valid(in_valid),
    .in_id(in_id), .coef_i(coef_i), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_id(out_id)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'hff;
  endfunction

  task automatic load_coefs();
    for (int k = 0; k < H; k++) coef_i[k*CW +: CW] = CW'(cf[k]);
  endtask

  task automatic clear_hist();
    for (int k = 0; k < N; k++) hist[k] = 0;
  endtask

  function automatic longint ref_out();
    longint s = 0;
    for (int k = 0; k < N; k++) s += cf[(k < H) ? k : N - 1 - k] * hist[k];
    return s;
  endfunction

  task automatic send(input int d, input bit garbage);
    longint exp;
    logic [OW-1:0] held;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    tag = tag + 1'b1;
    in_data  = DW'(d);
    in_id    = tag;
    in_valid = 1'b1;
    @(negedge clk);
    for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(DW'(d)));
    exp = ref_out();
    chk(!in_ready, "R3 ready low after accept", in_ready, 0);
    if (garbage) begin
      in_data = DW'(~d);
      in_id   = ~tag;
    end else begin
      in_valid = 1'b0;
    end
    for (int j = 1; j < H; j++) @(negedge clk);
    chk(!out_valid && !in_ready, "R3 busy through H cycles", {out_valid, in_ready}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, "R5 result pulse due", out_valid, 1);
    chk(in_ready, "R3 ready back with result", in_ready, 1);
    chk(longint'($signed(out_data)) == exp, garbage ? "R4 busy input ignored" : "R1 R2 filtered value",
        longint'($signed(out_data)), exp);
    chk(out_id == tag, "R6 tag returned", out_id, tag);
    held = out_data;
    @(negedge clk);
    chk(!out_valid && out_data == held, "R5 held after pulse", out_data, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; srst_n = 1'b1; in_valid = 1'b0; in_data = '0; in_id = '0; coef_i = '0;
    clear_hist();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && out_data == 0 && out_id == 0, "R7 reset state",
        {in_ready, out_valid}, 2);

    // R2 fold: unit coefficient on each half position in turn, impulse in
    for (int p = 0; p < H; p++) begin
      for (int k = 0; k < H; k++) cf[k] = (k == p) ? 1 : 0;
      load_coefs();
      send(5, 1'b0);
      for (int k = 0; k < N; k++) send(0, 1'b0);
    end

    // R1 extremes: full precision at both signs
    for (int k = 0; k < H; k++) cf[k] = -128;
    load_coefs();
    for (int k = 0; k < N; k++) send(-128, 1'b0);
    for (int k = 0; k < H; k++) cf[k] = 127;
    load_coefs();
    for (int k = 0; k < N; k++) send(-128, 1'b0);
    for (int k = 0; k < N; k++) send(127, 1'b0);

    // R1 sweep of data with random coefficient sets
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < H; k++) cf[k] = longint'($signed(CW'(rnd())));
      load_coefs();
      for (int d = -128; d < 128; d += 17) send(d, 1'b0);
    end

    // R4 garbage during busy cycles
    for (int i = 0; i < 6; i++) send(rnd() - 128, 1'b1);

    // R8 synchronous reset mid-accumulation
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = 8'd77; in_id = 4'd9; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    srst_n = 1'b0;
    @(negedge clk);
    srst_n = 1'b1;
    chk(in_ready && !out_valid && out_data == 0 && out_id == 0, "R8 sync reset clears",
        {in_ready, out_valid}, 2);
    clear_hist();
    send(33, 1'b0);

    // R7 asynchronous reset mid-accumulation
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = 8'd90; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk(in_ready && !out_valid && out_data == 0 && out_id == 0, "R7 async reset immediate",
           {in_ready, out_valid}, 2);
    @(negedge clk);
    rst_n = 1'b1;
    clear_hist();
    send(-61, 1'b0);
    send(100, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule